// File: doc/BRIEF.md
# Program Status Word Access Unit

This block holds the processor's 32-bit status word. The word packs three sub-registers into fixed bit positions: the application flags, the execution-state fields and the number of the active exception. Software reaches the word through move-to and move-from status requests. A 3-bit view code picks any non-empty set of the three sub-registers, and access rules apply per field and per privilege level.

The block also has internal update ports. The datapath uses one to refresh the flags, the pipeline uses one to load the execution-state fields, and exception entry and return use one to load the exception number. A raw output always shows the whole word, execution state included, so that exception logic can stack the full value.

Software reads are combinational from the stored word. Software writes and internal updates take effect at the next rising clock edge.

Top module: `psr_access_unit`

## Requirements
- R1: While `rst_n` is low, the stored word becomes 0x0100_0000. In that value only bit 24, the instruction-set state bit, is set.
- R2: The word layout has four parts:
  - Flags sit at N=31, Z=30, C=29, V=28 and Q=27, which are `flag_upd_val[4:0]` and `wr_data[31:27]` in that order.
  - Execution state sits at bits 26:24 (`exec_upd_val[8:6]`) and bits 15:10 (`exec_upd_val[5:0]`).
  - The exception number sits at bits 6:0.
  - Every other bit of `raw_word` is always zero.
- R3: The view code works bit by bit: bit 0 selects the flags, bit 1 the execution state and bit 2 the exception number. Code 3'b001 is the flags-only view. A permitted read returns, in the same cycle, the bits of the selected sub-registers and zero in every other position.
- R4: Execution-state positions always read as zero on `rd_data`, whatever the view and privilege.
- R5: Software writes never change the execution-state fields or the exception number, through any view.
- R6: A permitted software write loads `wr_data[31:27]` into the flags at the next edge when the view selects the flags. The flags keep their value when the view does not select them.
- R7: An unprivileged request may use only the flags-only view. An unprivileged read through any other view returns all zeros.
- R8: An unprivileged write through any view other than flags-only changes nothing. It raises `wr_denied` for exactly the one cycle after the write. `wr_denied` stays low after a permitted write.
- R9: Each internal update port, when enabled, loads its field at the next edge.
- R10: When a permitted software flag write and a datapath flag update fall in the same cycle, the software value is stored.
- R11: `raw_word` always presents the full stored word, execution-state bits included, with no privilege or view masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| rd_view | input | 3 | View code for software reads |
| rd_priv | input | 1 | Read request is privileged |
| rd_data | output | 32 | Masked read result |
| wr_en | input | 1 | Software write request |
| wr_view | input | 3 | View code for software writes |
| wr_priv | input | 1 | Write request is privileged |
| wr_data | input | 32 | Software write value |
| wr_denied | output | 1 | One-cycle strobe for a refused write |
| flag_upd_en | input | 1 | Datapath flag update enable |
| flag_upd_val | input | 5 | New N,Z,C,V,Q flags |
| exec_upd_en | input | 1 | Pipeline execution-state update enable |
| exec_upd_val | input | 9 | New execution-state fields |
| exc_upd_en | input | 1 | Exception-number update enable |
| exc_upd_num | input | 7 | New exception number |
| raw_word | output | 32 | Unmasked stored word |

## Verification
Read results depend only on the current inputs and the stored word, so the bench changes the view or privilege at a falling edge and samples `rd_data` a nanosecond later, within the same cycle. Software writes and internal updates pass through exactly one register. The bench therefore holds each request for one rising edge and then checks `raw_word` at the following falling edge. `wr_denied` is registered from the write request: it is checked high at the falling edge right after the offending write and low one cycle later.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int WORD_W      = 32;
    localparam int FLAG_W      = 5;
    localparam int FLAG_LSB    = 27;
    localparam int EXH_W       = 3;
    localparam int EXH_LSB     = 24;
    localparam int EXL_W       = 6;
    localparam int EXL_LSB     = 10;
    localparam int EXEC_W      = EXH_W + EXL_W;
    localparam int EXC_W       = 7;
    localparam int VIEW_W      = 3;
    localparam int SEL_FLAGS   = 0;
    localparam int SEL_EXEC    = 1;
    localparam int SEL_EXC     = 2;

    localparam logic [VIEW_W-1:0] VIEW_FLAGS_ONLY = 3'b001;
    localparam logic [EXEC_W-1:0] EXEC_RESET      = 9'b001_000000;

    typedef struct packed {
        logic flags_en;
        logic exec_en;
        logic exc_en;
        logic denied;
    } gate_t;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [FLAG_W-1:0] f,
        input logic [EXEC_W-1:0] e,
        input logic [EXC_W-1:0]  x,
        input logic              f_en,
        input logic              e_en,
        input logic              x_en
    );
        logic [WORD_W-1:0] w;
        w = '0;
        if (f_en) w[FLAG_LSB +: FLAG_W] = f;
        if (e_en) begin
            w[EXH_LSB +: EXH_W] = e[EXL_W +: EXH_W];
            w[EXL_LSB +: EXL_W] = e[EXL_W-1:0];
        end
        if (x_en) w[EXC_W-1:0] = x;
        return w;
    endfunction
endpackage

// File: rtl/psr_view_gate.sv
module psr_view_gate
    import psr_pkg::*;
(
    input  logic [VIEW_W-1:0] view,
    input  logic              priv,
    output gate_t             gate
);
    logic allowed;

    always_comb begin
        allowed       = priv || (view == VIEW_FLAGS_ONLY);
        gate.flags_en = allowed && view[SEL_FLAGS];
        gate.exec_en  = allowed && view[SEL_EXEC];
        gate.exc_en   = allowed && view[SEL_EXC];
        gate.denied   = !allowed;
    end
endmodule

// File: rtl/psr_fields.sv
module psr_fields
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_flag_we,
    input  logic [FLAG_W-1:0] sw_flags,
    input  logic              flag_upd_en,
    input  logic [FLAG_W-1:0] flag_upd_val,
    input  logic              exec_upd_en,
    input  logic [EXEC_W-1:0] exec_upd_val,
    input  logic              exc_upd_en,
    input  logic [EXC_W-1:0]  exc_upd_num,
    output logic [FLAG_W-1:0] flags_q,
    output logic [EXEC_W-1:0] exec_q,
    output logic [EXC_W-1:0]  exc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            exec_q  <= EXEC_RESET;
            exc_q   <= '0;
        end else begin
            if (sw_flag_we)       flags_q <= sw_flags;
            else if (flag_upd_en) flags_q <= flag_upd_val;
            if (exec_upd_en)      exec_q  <= exec_upd_val;
            if (exc_upd_en)       exc_q   <= exc_upd_num;
        end
    end
endmodule

// File: rtl/psr_access_unit.sv
module psr_access_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VIEW_W-1:0] rd_view,
    input  logic              rd_priv,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [VIEW_W-1:0] wr_view,
    input  logic              wr_priv,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_denied,
    input  logic              flag_upd_en,
    input  logic [FLAG_W-1:0] flag_upd_val,
    input  logic              exec_upd_en,
    input  logic [EXEC_W-1:0] exec_upd_val,
    input  logic              exc_upd_en,
    input  logic [EXC_W-1:0]  exc_upd_num,
    output logic [WORD_W-1:0] raw_word
);
    gate_t             rd_gate;
    gate_t             wr_gate;
    logic [FLAG_W-1:0] flags_q;
    logic [EXEC_W-1:0] exec_q;
    logic [EXC_W-1:0]  exc_q;
    logic              sw_flag_we;
    logic              denied_q;

    psr_view_gate u_rd_gate (.view(rd_view), .priv(rd_priv), .gate(rd_gate));
    psr_view_gate u_wr_gate (.view(wr_view), .priv(wr_priv), .gate(wr_gate));

    assign sw_flag_we = wr_en && wr_gate.flags_en;

    psr_fields u_fields (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_flag_we   (sw_flag_we),
        .sw_flags     (wr_data[FLAG_LSB +: FLAG_W]),
        .flag_upd_en  (flag_upd_en),
        .flag_upd_val (flag_upd_val),
        .exec_upd_en  (exec_upd_en),
        .exec_upd_val (exec_upd_val),
        .exc_upd_en   (exc_upd_en),
        .exc_upd_num  (exc_upd_num),
        .flags_q      (flags_q),
        .exec_q       (exec_q),
        .exc_q        (exc_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) denied_q <= 1'b0;
        else        denied_q <= wr_en && wr_gate.denied;
    end

    always_comb begin
        // Execution-state request is honoured as a selection but never exposed.
        rd_data  = pack_word(flags_q, '0, exc_q,
                             rd_gate.flags_en, rd_gate.exec_en && 1'b0, rd_gate.exc_en);
        raw_word = pack_word(flags_q, exec_q, exc_q, 1'b1, 1'b1, 1'b1);
    end

    assign wr_denied = denied_q;
endmodule

// File: rtl/psr_access_chk.sv
module psr_access_chk
    import psr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [VIEW_W-1:0] rd_view,
    input logic              rd_priv,
    input logic [WORD_W-1:0] rd_data,
    input logic              wr_en,
    input logic [VIEW_W-1:0] wr_view,
    input logic              wr_priv,
    input logic [WORD_W-1:0] wr_data,
    input logic              wr_denied,
    input logic              flag_upd_en,
    input logic [FLAG_W-1:0] flag_upd_val,
    input logic              exec_upd_en,
    input logic [EXEC_W-1:0] exec_upd_val,
    input logic              exc_upd_en,
    input logic [EXC_W-1:0]  exc_upd_num,
    input logic [WORD_W-1:0] raw_word
);
    localparam logic [WORD_W-1:0] EXEC_MASK = 32'h0700_FC00;
    localparam logic [WORD_W-1:0] RSVD_MASK = 32'h0000_0380 | 32'h00FF_0000;

    logic sw_flag;
    logic bad_wr;
    assign sw_flag = wr_en && wr_view[SEL_FLAGS] && (wr_priv || wr_view == VIEW_FLAGS_ONLY);
    assign bad_wr  = wr_en && !wr_priv && (wr_view != VIEW_FLAGS_ONLY);

    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> raw_word == 32'h0100_0000); // R1

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_word & RSVD_MASK) == '0); // R2

    AST_EXEC_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & EXEC_MASK) == '0); // R4

    AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_upd_en) |=> raw_word[EXC_W-1:0] == $past(raw_word[EXC_W-1:0])); // R5

    AST_UNPRIV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_priv && rd_view != VIEW_FLAGS_ONLY) |-> rd_data == '0); // R7

    AST_DENY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> wr_denied); // R8

    AST_NO_SPURIOUS_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_wr |=> !wr_denied); // R8

    AST_EXEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exec_upd_en |=> {raw_word[26:24], raw_word[15:10]} == $past(exec_upd_val)); // R9

    AST_EXC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_upd_en |=> raw_word[EXC_W-1:0] == $past(exc_upd_num)); // R9

    AST_FLAG_UPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd_en && !sw_flag) |=> raw_word[31:27] == $past(flag_upd_val)); // R9

    AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_flag |=> raw_word[31:27] == $past(wr_data[31:27])); // R10
endmodule

bind psr_access_unit psr_access_chk u_chk (.*);

// File: tb/tb_psr_access_unit.sv
`timescale 1ns/1ps
module tb_psr_access_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_view = '0;
    logic        rd_priv = 1'b0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_view = '0;
    logic        wr_priv = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_denied;
    logic        flag_upd_en = 1'b0;
    logic [4:0]  flag_upd_val = '0;
    logic        exec_upd_en = 1'b0;
    logic [8:0]  exec_upd_val = '0;
    logic        exc_upd_en = 1'b0;
    logic [6:0]  exc_upd_num = '0;
    logic [31:0] raw_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [4:0] m_flags;
    logic [8:0] m_exec;
    logic [6:0] m_exc;

    always #2.5 clk = ~clk;

    psr_access_unit dut (.*);

    function automatic logic [31:0] build(input logic [4:0] f, input logic [8:0] e,
                                          input logic [6:0] x);
        return {f, e[8:6], 8'h00, e[5:0], 3'b000, x};
    endfunction

    function automatic logic [31:0] view_exp(input logic [2:0] v);
        return (v[0] ? {m_flags, 27'h0} : 32'h0) | (v[2] ? {25'h0, m_exc} : 32'h0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [2:0] v, input logic p, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_view = v; wr_priv = p; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic read_at(input logic [2:0] v, input logic p, output logic [31:0] r);
        rd_view = v; rd_priv = p;
        #1 r = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        check("R1 reset word", raw_word, 32'h0100_0000);
        read_at(3'b111, 1'b1, r);
        check("R1 R4 reset read all", r, 32'h0);
        check("R8 denied low at reset", {31'h0, wr_denied}, 32'h0);
    endtask

    task automatic t_internal;
        @(negedge clk);
        flag_upd_en = 1'b1; flag_upd_val = 5'b10101;
        exec_upd_en = 1'b1; exec_upd_val = 9'h1FF;
        exc_upd_en = 1'b1;  exc_upd_num = 7'h2B;
        @(negedge clk);
        flag_upd_en = 1'b0; exec_upd_en = 1'b0; exc_upd_en = 1'b0;
        m_flags = 5'b10101; m_exec = 9'h1FF; m_exc = 7'h2B;
        check("R9 R11 raw after updates", raw_word, build(m_flags, m_exec, m_exc));
        check("R2 field positions", raw_word, 32'hAF00_FC2B);
    endtask

    task automatic t_views;
        logic [31:0] r;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            read_at(3'(v), 1'b1, r);
            check("R3 R4 privileged view read", r, view_exp(3'(v)));
        end
    endtask

    task automatic t_sw_write;
        sw_write(3'b111, 1'b1, 32'hFFFF_FFFF);
        m_flags = 5'h1F;
        check("R6 R5 full-view write", raw_word, build(m_flags, m_exec, m_exc));
        check("R2 reserved stay zero", raw_word & 32'h00FF_0380, 32'h0);
        sw_write(3'b110, 1'b1, 32'h0000_0000);
        check("R6 R5 write without flags", raw_word, build(m_flags, m_exec, m_exc));
        sw_write(3'b101, 1'b1, 32'h4000_0011);
        m_flags = 5'b01000;
        check("R6 R5 flags+exc write", raw_word, build(m_flags, m_exec, m_exc));
        check("R8 no deny on permitted", {31'h0, wr_denied}, 32'h0);
    endtask

    task automatic t_unpriv;
        logic [31:0] r;
        @(negedge clk);
        read_at(3'b001, 1'b0, r);
        check("R7 unpriv flags read", r, {m_flags, 27'h0});
        read_at(3'b111, 1'b0, r);
        check("R7 unpriv full read zero", r, 32'h0);
        read_at(3'b100, 1'b0, r);
        check("R7 unpriv exc read zero", r, 32'h0);
        sw_write(3'b001, 1'b0, 32'h9800_0000);
        m_flags = 5'b10011;
        check("R7 unpriv flags write", raw_word, build(m_flags, m_exec, m_exc));
        check("R8 no deny flags-only", {31'h0, wr_denied}, 32'h0);
        sw_write(3'b101, 1'b0, 32'h0000_0000);
        check("R8 denied strobe", {31'h0, wr_denied}, 32'h1);
        check("R8 denied write no change", raw_word, build(m_flags, m_exec, m_exc));
        @(negedge clk);
        check("R8 strobe one cycle", {31'h0, wr_denied}, 32'h0);
    endtask

    task automatic t_race;
        @(negedge clk);
        wr_en = 1'b1; wr_view = 3'b001; wr_priv = 1'b1; wr_data = 32'h5000_0000;
        flag_upd_en = 1'b1; flag_upd_val = 5'b11111;
        @(negedge clk);
        wr_en = 1'b0; flag_upd_en = 1'b0;
        m_flags = 5'b01010;
        check("R10 software beats datapath", raw_word, build(m_flags, m_exec, m_exc));
        @(negedge clk);
        wr_en = 1'b1; wr_view = 3'b100; wr_priv = 1'b1; wr_data = 32'h0800_0000;
        flag_upd_en = 1'b1; flag_upd_val = 5'b00110;
        @(negedge clk);
        wr_en = 1'b0; flag_upd_en = 1'b0;
        m_flags = 5'b00110;
        check("R9 R6 datapath when view lacks flags", raw_word, build(m_flags, m_exec, m_exc));
    endtask

    task automatic t_exc_return;
        @(negedge clk);
        exc_upd_en = 1'b1; exc_upd_num = 7'h00;
        exec_upd_en = 1'b1; exec_upd_val = 9'b001_000000;
        @(negedge clk);
        exc_upd_en = 1'b0; exec_upd_en = 1'b0;
        m_exc = 7'h00; m_exec = 9'b001_000000;
        check("R9 R11 exception return", raw_word, build(m_flags, m_exec, m_exc));
    endtask

    initial begin
        m_flags = '0; m_exec = 9'b001_000000; m_exc = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_internal();
        t_views();
        t_sw_write();
        t_unpriv();
        t_race();
        t_exc_return();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule